// File: doc/BRIEF.md
# Clocked Serial-ID Byte Streamer

A small security peripheral that hands a 16-byte identity record to a host one byte at a time. The host controls a clock bit in software: bit 4 of each byte it writes to the command port is that clock. A write with bit 4 low is a clocking write. On a clocking write the output buffer loads one of two things. If the low nibble of the write is zero, it loads the next record byte. If the low nibble is nonzero, it loads an echo of the written byte with a fixed mask ORed in, which lets a self-test confirm the port works. A single status flag follows the clock bit on writes and is forced high by data reads.

The record comes from a parameter when the asynchronous reset is applied. A byte-addressed preload port can overwrite it afterwards. A synchronous clear input restarts the stream without touching the record.

Top module: `sid_streamer`

## Requirements
- R1: On every write, `stat_o` takes the value of bit 4 of `wr_data_i` in the next cycle.
- R2: A write with bit 4 = 1 leaves `rd_data_o` and the record position unchanged.
- R3: A write with bit 4 = 0 and a nonzero low nibble (bits 3:0) loads the buffer with `wr_data_i | ECHO_MASK` and leaves the record position unchanged. The default `ECHO_MASK` is 8'h80, and 8'h00 is also valid.
- R4: A write with bit 4 = 0 and a low nibble of zero loads the buffer with the record byte at the current position, then advances the position by one. After position 15 the position returns to 0.
- R5: A read strobe sets `stat_o` to 1 in the next cycle. `rd_data_o` always shows the buffer.
- R6: When a read and a write happen in the same cycle, the write's status value wins.
- R7: While `clr_i` is high, the next edge clears the position, the status and the buffer to 0. This takes priority over any write or read in the same cycle.
- R8: A preload strobe writes `ld_data_i` into record byte `ld_addr_i` (4 bits). A clocking fetch in the same cycle returns the old byte. A preload is ignored while `clr_i` is high.
- R9: After `rst_ni` is released, status, buffer and position are 0, and record byte i holds `REC_INIT[8*i +: 8]`. By default that byte is 8'h5A ^ (8'h11 * i).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clr_i | input | 1 | Synchronous stream clear, active high |
| wr_i | input | 1 | Command write strobe |
| wr_data_i | input | 8 | Command byte (bit 4 = software clock) |
| rd_i | input | 1 | Data read strobe |
| rd_data_o | output | 8 | Output buffer |
| stat_o | output | 1 | Status flag |
| ld_we_i | input | 1 | Record preload strobe |
| ld_addr_i | input | 4 | Record preload byte address |
| ld_data_i | input | 8 | Record preload byte |

## Verification
The bench streams the whole record with repeated high/low clock pairs and continues past the end, which tests both the byte order and the wrap from 15 to 0. It mixes in echo writes with several nonzero nibbles, and bit-4-high writes that carry a zero nibble. These show that the nibble selects the echo path, that bit 4 alone gates clocking, and that the position does not move on echo writes. A read and a write in the same cycle show which status update wins. Preloads are issued in three situations: in the same cycle as a fetch from that address, while clear is high, and in isolation. A later fetch of each address shows the old-byte ordering, the clear override and the new content.

// File: rtl/sid_pkg.sv
package sid_pkg;
  localparam int unsigned SID_BYTES = 16;
  localparam int unsigned SID_DW    = 8;

  function automatic logic [SID_BYTES*SID_DW-1:0] sid_default_rec();
    logic [SID_BYTES*SID_DW-1:0] r;
    for (int i = 0; i < SID_BYTES; i++) begin
      r[i*SID_DW +: SID_DW] = 8'h5A ^ SID_DW'(8'h11 * i);
    end
    return r;
  endfunction
endpackage

// File: rtl/sid_record.sv
module sid_record #(
  parameter int unsigned DW    = 8,
  parameter int unsigned DEPTH = 16,
  parameter int unsigned AW    = $clog2(DEPTH),
  parameter logic [DEPTH*DW-1:0] INIT = '0
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);
  logic [DW-1:0] mem_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                           mem_q[g] <= INIT[g*DW +: DW];
      else if (we_i && waddr_i == AW'(g))    mem_q[g] <= wdata_i;
    end
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/sid_index.sv
module sid_index #(
  parameter int unsigned AW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          adv_i,
  output logic [AW-1:0] idx_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    idx_o <= '0;
    else if (clr_i) idx_o <= '0;
    else if (adv_i) idx_o <= idx_o + 1'b1; // natural wrap at 2**AW
  end
endmodule

// File: rtl/sid_out_stage.sv
module sid_out_stage #(
  parameter int unsigned DW      = 8,
  parameter int unsigned CLK_BIT = 4,
  parameter int unsigned NIB_W   = 4,
  parameter logic [DW-1:0] MASK  = 8'h80
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          wr_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic          rd_i,
  input  logic [DW-1:0] rec_byte_i,
  output logic          fetch_o,
  output logic [DW-1:0] buf_o,
  output logic          stat_o
);
  logic clk_low, echo_sel;

  assign clk_low  = wr_i && !wr_data_i[CLK_BIT];
  assign echo_sel = |wr_data_i[NIB_W-1:0];
  assign fetch_o  = !clr_i && clk_low && !echo_sel;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      buf_o  <= '0;
      stat_o <= 1'b0;
    end else if (clr_i) begin
      buf_o  <= '0;
      stat_o <= 1'b0;
    end else begin
      if (clk_low) buf_o <= echo_sel ? (wr_data_i | MASK) : rec_byte_i;
      // write status applied after read status
      if (wr_i)      stat_o <= wr_data_i[CLK_BIT];
      else if (rd_i) stat_o <= 1'b1;
    end
  end
endmodule

// File: rtl/sid_streamer.sv
module sid_streamer
  import sid_pkg::*;
#(
  parameter int unsigned DW      = SID_DW,
  parameter int unsigned DEPTH   = SID_BYTES,
  parameter int unsigned CLK_BIT = 4,
  parameter logic [DW-1:0] ECHO_MASK = 8'h80,
  parameter logic [DEPTH*DW-1:0] REC_INIT = sid_default_rec(),
  localparam int unsigned AW = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          wr_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic          rd_i,
  output logic [DW-1:0] rd_data_o,
  output logic          stat_o,
  input  logic          ld_we_i,
  input  logic [AW-1:0] ld_addr_i,
  input  logic [DW-1:0] ld_data_i
);
  logic [AW-1:0] idx_q;
  logic [DW-1:0] rec_byte;
  logic          fetch;

  sid_record #(.DW(DW), .DEPTH(DEPTH), .AW(AW), .INIT(REC_INIT)) u_rec (
    .clk_i, .rst_ni,
    .we_i    (ld_we_i && !clr_i),
    .waddr_i (ld_addr_i),
    .wdata_i (ld_data_i),
    .raddr_i (idx_q),
    .rdata_o (rec_byte)
  );

  sid_index #(.AW(AW)) u_idx (
    .clk_i, .rst_ni, .clr_i,
    .adv_i (fetch),
    .idx_o (idx_q)
  );

  sid_out_stage #(.DW(DW), .CLK_BIT(CLK_BIT), .NIB_W(CLK_BIT), .MASK(ECHO_MASK)) u_out (
    .clk_i, .rst_ni, .clr_i, .wr_i, .wr_data_i, .rd_i,
    .rec_byte_i (rec_byte),
    .fetch_o    (fetch),
    .buf_o      (rd_data_o),
    .stat_o
  );
endmodule

// File: rtl/sid_streamer_chk.sv
module sid_streamer_chk #(
  parameter int unsigned DW = 8,
  parameter int unsigned AW = 4,
  parameter int unsigned CLK_BIT = 4,
  parameter logic [DW-1:0] MASK = 8'h80
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          clr_i,
  input logic          wr_i,
  input logic [DW-1:0] wr_data_i,
  input logic          rd_i,
  input logic [DW-1:0] rd_data_o,
  input logic          stat_o,
  input logic [AW-1:0] idx_q
);
  logic clk_wr;
  assign clk_wr = wr_i && !wr_data_i[CLK_BIT] && !clr_i;

  p_wr_status_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i && !clr_i |=> stat_o == $past(wr_data_i[CLK_BIT]));

  p_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i && wr_data_i[CLK_BIT] && !clr_i |=> $stable(rd_data_o) && $stable(idx_q));

  p_echo_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clk_wr && (|wr_data_i[CLK_BIT-1:0]) |=>
      rd_data_o == ($past(wr_data_i) | MASK) && $stable(idx_q));

  p_advance_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clk_wr && !(|wr_data_i[CLK_BIT-1:0]) |=> idx_q == AW'($past(idx_q) + 1'b1));

  p_rd_status_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i && !wr_i && !clr_i |=> stat_o);

  p_clear_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> !stat_o && rd_data_o == '0 && idx_q == '0);
endmodule

bind sid_streamer sid_streamer_chk #(.DW(DW), .AW(AW), .CLK_BIT(CLK_BIT), .MASK(ECHO_MASK)) u_chk (
  .clk_i, .rst_ni, .clr_i, .wr_i, .wr_data_i, .rd_i, .rd_data_o, .stat_o, .idx_q
);

// File: tb/sid_streamer_tb_top.sv
module sid_streamer_tb_top;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       clr_i = 1'b0, wr_i = 1'b0, rd_i = 1'b0, ld_we_i = 1'b0;
  logic [7:0] wr_data_i = '0, ld_data_i = '0;
  logic [3:0] ld_addr_i = '0;
  logic [7:0] rd_data_o;
  logic       stat_o;

  int errors = 0, checks = 0;
  bit done = 0;

  // behavioural reference
  byte unsigned m_rec [16];
  int  m_idx;
  byte unsigned m_buf;
  bit  m_st;

  always #4 clk_i = ~clk_i;

  sid_streamer dut_i (.*);

  task automatic check(string tag);
    checks++;
    if (rd_data_o !== m_buf) begin
      errors++;
      $display("FAIL %s data got %h exp %h", tag, rd_data_o, m_buf);
    end
    checks++;
    if (stat_o !== m_st) begin
      errors++;
      $display("FAIL %s status got %b exp %b", tag, stat_o, m_st);
    end
  endtask

  task automatic step(string tag, bit c, bit w, byte unsigned wd, bit r,
                      bit l = 0, int la = 0, byte unsigned ld = 0);
    byte unsigned fetched;
    clr_i = c; wr_i = w; wr_data_i = wd; rd_i = r;
    ld_we_i = l; ld_addr_i = 4'(la); ld_data_i = ld;
    @(posedge clk_i);
    fetched = m_rec[m_idx];
    if (c) begin
      m_idx = 0; m_st = 0; m_buf = 0;
    end else begin
      if (r) m_st = 1;
      if (w) begin
        m_st = wd[4];
        if (!wd[4]) begin
          if ((wd & 8'h0f) != 0) m_buf = wd | 8'h80;
          else begin m_buf = fetched; m_idx = (m_idx + 1) % 16; end
        end
      end
      if (l) m_rec[la] = ld;
    end
    @(negedge clk_i);
    clr_i = 0; wr_i = 0; rd_i = 0; ld_we_i = 0;
    check(tag);
  endtask

  task automatic next_byte(string tag);
    step(tag, 0, 1, 8'h10, 0);
    step(tag, 0, 1, 8'h00, 0);
  endtask

  initial begin
    #(8 * 5000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 16; i++) m_rec[i] = 8'h5A ^ 8'(8'h11 * i);
    m_idx = 0; m_buf = 0; m_st = 0;
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R9 reset");
    // R4 full stream plus wrap
    for (int i = 0; i < 18; i++) next_byte("R4 stream");
    // R3 echo paths, R1 status
    step("R1 clk high", 0, 1, 8'h1F, 0);
    step("R3 echo 0F", 0, 1, 8'h0F, 0);
    step("R3 echo 05", 0, 1, 8'h05, 0);
    step("R3 echo 41", 0, 1, 8'h41, 0);
    // R2 bit4 high with zero nibble: no clock
    step("R2 hold", 0, 1, 8'h10, 0);
    step("R2 hold", 0, 1, 8'hF0, 0);
    next_byte("R4 after echo");
    // R5 read
    step("R5 read", 0, 0, 8'h00, 1);
    step("R1 write low", 0, 1, 8'h03, 0);
    // R6 read + write same cycle
    step("R6 rd+wr", 0, 1, 8'h00, 1);
    step("R6 rd+wr high", 0, 1, 8'h10, 1);
    step("R5 read again", 0, 0, 8'h00, 1);
    // R7 clear, with write in same cycle
    step("R7 clear", 1, 1, 8'h00, 1);
    step("R7 clear echo", 1, 1, 8'h07, 0);
    // R8 preload at current fetch address, same cycle as fetch
    step("R1 pre", 0, 1, 8'h10, 0);
    step("R8 fetch old", 0, 1, 8'h00, 0, 1, 0, 8'hC3);
    step("R8 load", 0, 0, 8'h00, 0, 1, 1, 8'h9E);
    step("R8 clr ignore", 1, 0, 8'h00, 0, 1, 2, 8'h77);
    for (int i = 0; i < 4; i++) next_byte("R8 read back");
    for (int i = 0; i < 16; i++) next_byte("R4 wrap again");
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule